// File: doc/BRIEF.md
# Event Timer Main Counter

This block is the time base of a multi-channel event timer. It keeps a 64-bit up-counter that advances by one on every clock while a global enable is set. It also holds a small general configuration word with two bits, enable and legacy interrupt routing. The count and the enable state are broadcast on plain output pins to the comparator channels that sit beside the block.

Software reaches the block through a 32-bit register port. A request channel uses valid/ready. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while reset is held. It never drops for back-pressure, so a caller may present one request per cycle. Read data returns one cycle after acceptance, marked by a single-cycle `rsp_valid` strobe. The response has no ready, so the caller must be able to take it in that cycle. Writes give no response.

The 64-bit count is seen as two 32-bit words. Each word can be overwritten on its own. Clearing the enable bit freezes the count where it stands, and setting it again resumes counting from that held value.

Top module: `evt_main_counter`

## Requirements
- R1: While reset is held and after it is released, the count is zero, enable and legacy routing are clear, the warning output is low and `rsp_valid` is low. `req_ready` is low during reset and high after it.
- R2: A word read at offset 0x00 returns the identification value 0x8086A201. A word read at offset 0x04 returns the tick period in femtoseconds (parameter `TICK_FS`). Writes to both offsets change nothing.
- R3: While enable is set and no count write is taken, the count grows by exactly one per clock. A carry passes from bit 31 into bit 32, and the count wraps from all ones to zero.
- R4: A configuration write that clears enable stops the count. Every later read returns the held value. A write that sets enable again resumes counting from that value.
- R5: A word write to offset 0x20 replaces count bits 31:0, and a word write to offset 0x24 replaces bits 63:32. In both cases the other half keeps its value, whether enable is set or clear.
- R6: A read of offset 0x20 or 0x24 returns the matching half of the count as it stood in the cycle the read was accepted. While counting, this is the live value.
- R7: In the configuration word at offset 0x10, bit 0 is enable and bit 1 is legacy routing; they drive `count_en_o` and `legacy_route_o`. Its other bits read as zero. Offset 0x14 reads as zero, and writes to it change nothing.
- R8: A count write taken while enable is set raises `cnt_wr_warn_o` for exactly the next cycle. The write still takes effect.
- R9: An access that is unsupported changes no state. This covers `req_size` 0 (byte), 1 (16-bit) or 3, and any `req_addr[1:0]` that is not zero. A read of this kind, or of an unmapped offset, still responds, with zero data.
- R10: `rsp_valid` is high for exactly the one cycle after each accepted read, and never after a write.
- R11: `count_o` always equals the value that the two count offsets would read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_size | input | 2 | Access size: 0 byte, 1 16-bit, 2 word, 3 reserved |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid strobe |
| rsp_rdata | output | 32 | Read data |
| count_o | output | 64 | Broadcast main count |
| count_en_o | output | 1 | Broadcast enable state |
| legacy_route_o | output | 1 | Legacy routing bit |
| cnt_wr_warn_o | output | 1 | Count written while enabled (one-cycle pulse) |

## Verification
The assertions assume that `req_size` and `req_addr` are stable and defined whenever `req_valid` is high. They also assume that reset is applied before the first request. The stepping property on the count holds only in cycles with no count write, so the bench issues count writes only as whole accepted requests. The bench drives every input at falling edges and lowers `req_valid` just after the accepting edge, so each request is taken exactly once. It counts the accepting edges so that the expected count after each enable and disable is exact.

// File: rtl/evt_pkg.sv
package evt_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    RS_NONE   = 3'd0,
    RS_CAP_LO = 3'd1,
    RS_CAP_HI = 3'd2,
    RS_CFG    = 3'd3,
    RS_CNT_LO = 3'd4,
    RS_CNT_HI = 3'd5
  } rd_sel_e;

  // register offsets (bytes)
  localparam int unsigned OFF_CAP_LO = 32'h00;
  localparam int unsigned OFF_CAP_HI = 32'h04;
  localparam int unsigned OFF_CFG_LO = 32'h10;
  localparam int unsigned OFF_CFG_HI = 32'h14;
  localparam int unsigned OFF_CNT_LO = 32'h20;
  localparam int unsigned OFF_CNT_HI = 32'h24;

  // configuration bit positions
  localparam int unsigned CFG_EN_BIT  = 0;
  localparam int unsigned CFG_LEG_BIT = 1;

endpackage

// File: rtl/evt_reg_decode.sv
module evt_reg_decode
  import evt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              req_valid,
  input  logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic              rd_go,
  output rd_sel_e           rd_sel,
  output logic              wr_cfg,
  output logic [1:0]        wr_cnt,
  output logic              bad_acc
);

  logic taken;
  logic legal;

  always_comb begin
    taken   = req_valid && req_ready;
    legal   = (req_size == SZ_WORD) && (req_addr[1:0] == 2'b00);
    bad_acc = taken && !legal;

    rd_go   = taken && !req_write;
    rd_sel  = RS_NONE;
    wr_cfg  = 1'b0;
    wr_cnt  = 2'b00;

    if (taken && legal) begin
      if (req_write) begin
        wr_cfg    = (req_addr == ADDR_W'(OFF_CFG_LO));
        wr_cnt[0] = (req_addr == ADDR_W'(OFF_CNT_LO));
        wr_cnt[1] = (req_addr == ADDR_W'(OFF_CNT_HI));
      end else begin
        if      (req_addr == ADDR_W'(OFF_CAP_LO)) rd_sel = RS_CAP_LO;
        else if (req_addr == ADDR_W'(OFF_CAP_HI)) rd_sel = RS_CAP_HI;
        else if (req_addr == ADDR_W'(OFF_CFG_LO)) rd_sel = RS_CFG;
        else if (req_addr == ADDR_W'(OFF_CNT_LO)) rd_sel = RS_CNT_LO;
        else if (req_addr == ADDR_W'(OFF_CNT_HI)) rd_sel = RS_CNT_HI;
        else                                      rd_sel = RS_NONE;
      end
    end
  end

endmodule

// File: rtl/evt_cfg_reg.sv
module evt_cfg_reg
  import evt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cfg,
  input  logic [1:0]        wdata,
  output logic              en_o,
  output logic              legacy_o,
  output logic [DATA_W-1:0] cfg_word
);

  logic en_q, leg_q;
  logic en_rise, en_fall;

  // enable edges, from held value and incoming value
  always_comb begin
    en_rise = wr_cfg && !en_q &&  wdata[CFG_EN_BIT];
    en_fall = wr_cfg &&  en_q && !wdata[CFG_EN_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      leg_q <= 1'b0;
    end else if (wr_cfg) begin
      en_q  <= wdata[CFG_EN_BIT];
      leg_q <= wdata[CFG_LEG_BIT];
    end
  end

  always_comb begin
    cfg_word              = '0;
    cfg_word[CFG_EN_BIT]  = en_q;
    cfg_word[CFG_LEG_BIT] = leg_q;
  end

  assign en_o     = en_q;
  assign legacy_o = leg_q;

  // R4: a start edge leaves enable set, a stop edge leaves it clear
  p_start_edge_r4: assert property (@(posedge clk) disable iff (rst)
    en_rise |=> en_q);
  p_stop_edge_r4: assert property (@(posedge clk) disable iff (rst)
    en_fall |=> !en_q);
  // R7: without a configuration write both bits hold
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_cfg |=> ($stable(en_q) && $stable(leg_q)));

endmodule

// File: rtl/evt_count_core.sv
module evt_count_core #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NHALF = 2,
  localparam int unsigned CNT_W = NHALF * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [NHALF-1:0]  wr_half_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              warn_o
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] merged;
  logic             warn_q;

  // merge a written half into the current count
  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign merged[h*DATA_W +: DATA_W] =
      wr_half_i[h] ? wdata_i : count_q[h*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      warn_q  <= 1'b0;
    end else begin
      warn_q <= en_i && (|wr_half_i);
      if (|wr_half_i)
        count_q <= merged;
      else if (en_i)
        count_q <= count_q + CNT_W'(1);
    end
  end

  assign count_o = count_q;
  assign warn_o  = warn_q;

  // R3: one step per clock while running and not written
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (en_i && !(|wr_half_i)) |=> (count_q == $past(count_q) + CNT_W'(1)));
  // R4: held while stopped and not written
  p_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !(|wr_half_i)) |=> $stable(count_q));
  // R5: writing the low half keeps the high half
  p_keep_hi_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_half_i == 2'b01) |=> (count_q[CNT_W-1:DATA_W] == $past(count_q[CNT_W-1:DATA_W])));
  // R5: writing the high half keeps the low half
  p_keep_lo_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_half_i == 2'b10) |=> (count_q[DATA_W-1:0] == $past(count_q[DATA_W-1:0])));
  // R5: at most one half per request
  p_one_half_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_half_i));

endmodule

// File: rtl/evt_rd_mux.sv
module evt_rd_mux
  import evt_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter logic [31:0] CAP_ID  = 32'h8086A201,
  parameter int unsigned TICK_FS = 4000000,
  localparam int unsigned CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_go,
  input  rd_sel_e           rd_sel,
  input  logic [DATA_W-1:0] cfg_word,
  input  logic [CNT_W-1:0]  count,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [DATA_W-1:0] pick;
  logic              vld_q;
  logic [DATA_W-1:0] dat_q;

  always_comb begin
    unique case (rd_sel)
      RS_CAP_LO: pick = DATA_W'(CAP_ID);
      RS_CAP_HI: pick = DATA_W'(TICK_FS);
      RS_CFG:    pick = cfg_word;
      RS_CNT_LO: pick = count[DATA_W-1:0];
      RS_CNT_HI: pick = count[CNT_W-1:DATA_W];
      default:   pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= rd_go;
      if (rd_go) dat_q <= pick;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_rdata = dat_q;

  // R10: one response per accepted read, one cycle later
  p_rsp_follows_r10: assert property (@(posedge clk) disable iff (rst)
    rd_go |=> rsp_valid);
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_go |=> !rsp_valid);

endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter
  import evt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter logic [31:0] CAP_ID  = 32'h8086A201,
  parameter int unsigned TICK_FS = 4000000,
  localparam int unsigned DATA_W = 32,
  localparam int unsigned CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [63:0]       count_o,
  output logic              count_en_o,
  output logic              legacy_route_o,
  output logic              cnt_wr_warn_o
);

  logic              rdy_q;
  logic              rd_go;
  rd_sel_e           rd_sel;
  logic              wr_cfg;
  logic [1:0]        wr_cnt;
  logic              bad_acc;
  logic              en;
  logic [DATA_W-1:0] cfg_word;
  logic [CNT_W-1:0]  count;

  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= 1'b1;
  end
  assign req_ready = rdy_q;

  evt_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid (req_valid),
    .req_ready (rdy_q),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rd_go     (rd_go),
    .rd_sel    (rd_sel),
    .wr_cfg    (wr_cfg),
    .wr_cnt    (wr_cnt),
    .bad_acc   (bad_acc)
  );

  evt_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_cfg   (wr_cfg),
    .wdata    (req_wdata[1:0]),
    .en_o     (en),
    .legacy_o (legacy_route_o),
    .cfg_word (cfg_word)
  );

  evt_count_core #(.DATA_W(DATA_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .en_i      (en),
    .wr_half_i (wr_cnt),
    .wdata_i   (req_wdata),
    .count_o   (count),
    .warn_o    (cnt_wr_warn_o)
  );

  evt_rd_mux #(
    .DATA_W  (DATA_W),
    .CAP_ID  (CAP_ID),
    .TICK_FS (TICK_FS)
  ) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_go     (rd_go),
    .rd_sel    (rd_sel),
    .cfg_word  (cfg_word),
    .count     (count),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  assign count_o    = count;
  assign count_en_o = en;

  // R1: ready is up in every cycle after reset
  p_ready_r1: assert property (@(posedge clk) disable iff (rst)
    !rst |=> req_ready);
  // R9: an unsupported write while stopped leaves all state alone
  p_bad_write_r9: assert property (@(posedge clk) disable iff (rst)
    (bad_acc && req_write && !en) |=> ($stable(count_o) && $stable(count_en_o) && $stable(legacy_route_o)));
  // R7: writes to the upper configuration word change nothing
  p_cfg_hi_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_write && req_addr == ADDR_W'(OFF_CFG_HI))
      |=> ($stable(count_en_o) && $stable(legacy_route_o)));
  // R8: the warning only follows a cycle in which counting was enabled
  p_warn_cause_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_wr_warn_o |-> $past(count_en_o));

endmodule

// File: tb/evt_main_counter_bench.sv
`timescale 1ns/1ps
module evt_main_counter_bench;

  localparam int unsigned AW = 8;
  localparam int unsigned TFS = 4000000;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_write;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic [31:0]   req_wdata;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [63:0]   count_o;
  logic          count_en_o, legacy_route_o, cnt_wr_warn_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  evt_main_counter #(.ADDR_W(AW), .TICK_FS(TFS)) u_evt_main_counter (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .count_o(count_o), .count_en_o(count_en_o),
    .legacy_route_o(legacy_route_o), .cnt_wr_warn_o(cnt_wr_warn_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // request accepted at the next rising edge; valid dropped 1 ns later
  task automatic do_wr(input logic [7:0] a, input logic [31:0] d,
                       input logic [1:0] sz = 2'd2);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_size = sz;
    @(posedge clk);
    #1 req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [31:0] d,
                       output logic v, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    v = rsp_valid; d = rsp_rdata;
  endtask

  task automatic rd_cnt(output logic [63:0] c);
    logic [31:0] lo, hi; logic v;
    do_rd(8'h20, lo, v);
    do_rd(8'h24, hi, v);
    c = {hi, lo};
  endtask

  task automatic set_cnt(input logic [63:0] c);
    do_wr(8'h24, c[63:32]);
    do_wr(8'h20, c[31:0]);
  endtask

  task automatic t_reset;
    rst = 1'b1; req_valid = 0; req_write = 0; req_addr = '0; req_size = 2'd2; req_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "ready in reset", req_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "count", count_o, 64'h0);
    chk("R1", "enable", count_en_o, 0);
    chk("R1", "legacy", legacy_route_o, 0);
    chk("R1", "warn", cnt_wr_warn_o, 0);
    chk("R1", "rsp_valid", rsp_valid, 0);
    chk("R1", "ready", req_ready, 1);
  endtask

  task automatic t_cap;
    logic [31:0] d; logic v;
    do_rd(8'h00, d, v);
    chk("R2", "id word", d, 32'h8086A201);
    chk("R10", "read strobe", v, 1);
    do_rd(8'h04, d, v);
    chk("R2", "tick period", d, TFS);
    do_wr(8'h00, 32'h0);
    do_wr(8'h04, 32'h1);
    do_rd(8'h00, d, v);
    chk("R2", "id after write", d, 32'h8086A201);
    do_rd(8'h04, d, v);
    chk("R2", "period after write", d, TFS);
  endtask

  task automatic t_cfg;
    logic [31:0] d; logic v;
    do_wr(8'h14, 32'h3);
    @(negedge clk);
    chk("R7", "enable after hi write", count_en_o, 0);
    chk("R7", "legacy after hi write", legacy_route_o, 0);
    do_rd(8'h14, d, v);
    chk("R7", "upper cfg reads zero", d, 0);
    do_wr(8'h10, 32'hFFFF_FFFE);
    @(negedge clk);
    chk("R7", "legacy set", legacy_route_o, 1);
    chk("R7", "enable clear", count_en_o, 0);
    do_rd(8'h10, d, v);
    chk("R7", "cfg readback", d, 32'h2);
    do_wr(8'h10, 32'h0);
    @(negedge clk);
    chk("R7", "legacy cleared", legacy_route_o, 0);
  endtask

  task automatic t_halves;
    logic [63:0] c;
    set_cnt(64'h1234_5678_9ABC_DEF0);
    rd_cnt(c);
    chk("R5", "full write", c, 64'h1234_5678_9ABC_DEF0);
    do_wr(8'h20, 32'h0000_0011);
    rd_cnt(c);
    chk("R5", "low only", c, 64'h1234_5678_0000_0011);
    do_wr(8'h24, 32'hCAFE_0000);
    rd_cnt(c);
    chk("R5", "high only", c, 64'hCAFE_0000_0000_0011);
    chk("R11", "broadcast equals read", count_o, c);
  endtask

  task automatic t_freeze;
    logic [63:0] c;
    set_cnt(64'h0000_0007_0000_0100);
    do_wr(8'h10, 32'h1);           // accepted at E0
    repeat (4) @(posedge clk);
    do_wr(8'h10, 32'h0);           // accepted at E0+5: five steps
    rd_cnt(c);
    chk("R4", "held after stop", c, 64'h0000_0007_0000_0105);
    repeat (10) @(posedge clk);
    rd_cnt(c);
    chk("R4", "still held", c, 64'h0000_0007_0000_0105);
    do_wr(8'h10, 32'h1);
    do_wr(8'h10, 32'h0);           // one step
    rd_cnt(c);
    chk("R4", "resume from held", c, 64'h0000_0007_0000_0106);
  endtask

  task automatic t_live;
    logic [31:0] d; logic v;
    set_cnt(64'h0000_0005_0000_0010);
    do_wr(8'h10, 32'h1);           // E0
    repeat (5) @(posedge clk);
    do_rd(8'h20, d, v);            // accepted E0+6: value before it = +5
    chk("R6", "live low read", d, 32'h15);
    do_rd(8'h24, d, v);
    chk("R6", "live high read", d, 32'h5);
    do_wr(8'h10, 32'h0);
  endtask

  task automatic t_carry_wrap;
    logic [63:0] c;
    set_cnt(64'h0000_0000_FFFF_FFFE);
    do_wr(8'h10, 32'h1);
    repeat (2) @(posedge clk);
    do_wr(8'h10, 32'h0);           // three steps
    rd_cnt(c);
    chk("R3", "carry into high half", c, 64'h0000_0001_0000_0001);
    set_cnt(64'hFFFF_FFFF_FFFF_FFFF);
    do_wr(8'h10, 32'h1);
    do_wr(8'h10, 32'h0);           // one step
    rd_cnt(c);
    chk("R3", "wrap to zero", c, 64'h0);
  endtask

  task automatic t_warn;
    logic [63:0] c;
    set_cnt(64'h0000_000A_0000_0000);
    @(negedge clk);
    chk("R8", "no warn when stopped", cnt_wr_warn_o, 0);
    do_wr(8'h10, 32'h1);
    do_wr(8'h20, 32'h100);         // Ew
    @(negedge clk);
    chk("R8", "warn pulse", cnt_wr_warn_o, 1);
    @(negedge clk);
    chk("R8", "warn one cycle", cnt_wr_warn_o, 0);
    do_wr(8'h10, 32'h0);           // accepted Ew+3: three steps
    rd_cnt(c);
    chk("R8", "write while running applied", c, 64'h0000_000A_0000_0103);
  endtask

  task automatic t_bad;
    logic [63:0] c; logic [31:0] d; logic v;
    set_cnt(64'h0000_0042_0000_0024);
    do_wr(8'h20, 32'hDEAD_BEEF, 2'd0);
    do_wr(8'h24, 32'hDEAD_BEEF, 2'd1);
    do_wr(8'h21, 32'hDEAD_BEEF);
    do_wr(8'h10, 32'h3, 2'd1);
    @(negedge clk);
    chk("R9", "enable untouched", count_en_o, 0);
    chk("R9", "legacy untouched", legacy_route_o, 0);
    rd_cnt(c);
    chk("R9", "count untouched", c, 64'h0000_0042_0000_0024);
    do_rd(8'h00, d, v, 2'd0);
    chk("R9", "byte read strobe", v, 1);
    chk("R9", "byte read data", d, 0);
    do_rd(8'h3C, d, v);
    chk("R9", "unmapped read data", d, 0);
  endtask

  task automatic t_proto;
    logic [31:0] d; logic v;
    do_wr(8'h20, 32'h5);
    @(negedge clk);
    chk("R10", "no response to write", rsp_valid, 0);
    do_rd(8'h00, d, v);
    chk("R10", "strobe after read", v, 1);
    @(negedge clk);
    chk("R10", "strobe one cycle", rsp_valid, 0);
  endtask

  initial begin
    t_reset();
    t_cap();
    t_cfg();
    t_halves();
    t_freeze();
    t_live();
    t_carry_wrap();
    t_warn();
    t_bad();
    t_proto();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule